// File: doc/BRIEF.md
# Circular Return Address Stack

This block predicts the targets of subroutine returns in a pipelined instruction fetch unit. A fixed number of return addresses sit in a ring of entries, addressed by a top-of-stack pointer. When the front end predicts a call, it pushes the return address. When it predicts a return, it pops. The entry under the pointer and the pointer itself are presented on the outputs at all times. This lets the front end read a predicted target with no delay and keep a copy of the pointer beside each predicted branch.

When a branch turns out to be mispredicted, the front end hands a saved pointer value and a corrected address to the restore port. The pointer jumps to that index, and that entry is overwritten. An occupancy count, separate from the pointer, drives the empty and full flags. Once the ring is full, further pushes wrap around and silently replace the oldest entries, while the count stays at the depth. Entry contents are not cleared by reset.

Top module: `ras_ring_top`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `top_idx` is 0, `empty` is 1 and `full` is 0.
- R2: A push alone (`push_en`=1, `pop_en`=0, `restore_en`=0) advances `top_idx` by one, wrapping from DEPTH-1 to 0. In the next cycle `top_addr` equals the pushed `push_addr`.
- R3: A pop alone with a nonzero occupancy moves `top_idx` back by one, wrapping from 0 to DEPTH-1, and lowers the occupancy by one.
- R4: A pop alone while `empty` is 1 changes neither `top_idx` nor the flags.
- R5: The occupancy never exceeds DEPTH. A push while `full` is 1 still advances the pointer and writes the entry, overwriting the oldest one, and `full` stays 1.
- R6: `top_addr` is always the content of the entry indexed by `top_idx`, with no extra cycle of latency after the pointer moves.
- R7: A restore (`restore_en`=1) sets `top_idx` to `restore_idx` and writes `restore_addr` into that entry, so the next cycle shows both. The occupancy and the flags are unchanged.
- R8: When `restore_en` is 1, `push_en` and `pop_en` are ignored in that cycle.
- R9: Push and pop together act as a pop followed by a push. With a nonzero occupancy, the pointer and the flags stay put and the top entry is replaced by `push_addr`. While empty, the pair behaves as a push alone.
- R10: `empty` is 1 exactly when the occupancy is 0, and `full` is 1 exactly when it equals DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| push_en | input | 1 | Push request (predicted call) |
| push_addr | input | AW | Return address to push |
| pop_en | input | 1 | Pop request (predicted return) |
| restore_en | input | 1 | Misprediction recovery request |
| restore_idx | input | $clog2(DEPTH) | Saved pointer value to return to, below DEPTH |
| restore_addr | input | AW | Corrected address for the restored top entry |
| top_addr | output | AW | Entry under the pointer |
| top_idx | output | $clog2(DEPTH) | Current top-of-stack pointer |
| empty | output | 1 | Occupancy is zero |
| full | output | 1 | Occupancy equals DEPTH |

## Verification
A pointer that steps the wrong way or misses a wrap shows on `top_idx` in the very next cycle. A misplaced write shows on `top_addr` as soon as the pointer lands on that entry, which can be several operations later. A drifting occupancy count is hidden until a flag boundary is reached. For that reason, the bench drives pushes and pops across both the empty and full edges, and then compares every output against a behavioural model on every clock.

// File: rtl/ras_pkg.sv
package ras_pkg;

    typedef enum logic [1:0] {
        OP_IDLE = 2'd0,
        OP_PUSH = 2'd1,
        OP_POP  = 2'd2,
        OP_SWAP = 2'd3
    } ras_op_e;

    function automatic ras_op_e ras_decode(input logic push, input logic pop);
        case ({pop, push})
            2'b01:   return OP_PUSH;
            2'b10:   return OP_POP;
            2'b11:   return OP_SWAP;
            default: return OP_IDLE;
        endcase
    endfunction

endpackage

// File: rtl/ras_wrap_step.sv
module ras_wrap_step #(
    parameter int DEPTH = 8,
    localparam int PW = $clog2(DEPTH)
) (
    input  logic [PW-1:0] cur,
    output logic [PW-1:0] nxt_up,
    output logic [PW-1:0] nxt_down
);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    always_comb begin
        nxt_up   = (cur == LAST) ? '0 : cur + 1'b1;
        nxt_down = (cur == '0) ? LAST : cur - 1'b1;
    end
endmodule

// File: rtl/ras_occ.sv
module ras_occ #(
    parameter int DEPTH = 8,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          up,
    input  logic          down,
    output logic [CW-1:0] count,
    output logic          empty,
    output logic          full
);
    localparam logic [CW-1:0] TOP = CW'(DEPTH);

    logic [CW-1:0] count_d, count_q;

    always_comb begin
        count_d = count_q;
        if (up && !down && count_q != TOP)
            count_d = count_q + 1'b1;
        else if (down && !up && count_q != '0)
            count_d = count_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) count_q <= '0;
        else     count_q <= count_d;
    end

    assign count = count_q;
    assign empty = (count_q == '0);
    assign full  = (count_q == TOP);

    assert_count_bound_R5: assert property (@(posedge clk) disable iff (rst)
        count_q <= TOP);

    assert_full_holds_on_push_R5: assert property (@(posedge clk) disable iff (rst)
        (full && up && !down) |=> full);

    assert_flags_exclusive_R10: assert property (@(posedge clk) disable iff (rst)
        !(empty && full));
endmodule

// File: rtl/ras_store.sv
module ras_store #(
    parameter int DEPTH = 8,
    parameter int AW = 32,
    localparam int PW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [PW-1:0] waddr,
    input  logic [AW-1:0] wdata,
    input  logic [PW-1:0] raddr,
    output logic [AW-1:0] rdata
);
    logic [AW-1:0] slots [DEPTH];

    always_ff @(posedge clk) begin
        if (we) slots[waddr] <= wdata;
    end

    assign rdata = slots[raddr];

    assert_write_lands_R6: assert property (@(posedge clk)
        we |=> slots[$past(waddr)] == $past(wdata));
endmodule

// File: rtl/ras_ring_top.sv
module ras_ring_top
    import ras_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int AW = 32,
    localparam int PW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push_en,
    input  logic [AW-1:0] push_addr,
    input  logic          pop_en,
    input  logic          restore_en,
    input  logic [PW-1:0] restore_idx,
    input  logic [AW-1:0] restore_addr,
    output logic [AW-1:0] top_addr,
    output logic [PW-1:0] top_idx,
    output logic          empty,
    output logic          full
);
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [PW-1:0] ptr;
        logic          we;
        logic [PW-1:0] waddr;
        logic [AW-1:0] wdata;
        logic          occ_up;
        logic          occ_down;
    } ctl_t;

    ctl_t          ctl_d;
    logic [PW-1:0] ptr_q;
    logic [PW-1:0] ptr_up, ptr_down;
    logic [CW-1:0] occ_count;
    ras_op_e       op;

    ras_wrap_step #(.DEPTH(DEPTH)) u_step (
        .cur      (ptr_q),
        .nxt_up   (ptr_up),
        .nxt_down (ptr_down)
    );

    always_comb begin
        op             = ras_decode(push_en, pop_en);
        ctl_d.ptr      = ptr_q;
        ctl_d.we       = 1'b0;
        ctl_d.waddr    = ptr_q;
        ctl_d.wdata    = push_addr;
        ctl_d.occ_up   = 1'b0;
        ctl_d.occ_down = 1'b0;
        if (restore_en) begin
            ctl_d.ptr   = restore_idx;
            ctl_d.we    = 1'b1;
            ctl_d.waddr = restore_idx;
            ctl_d.wdata = restore_addr;
        end else begin
            case (op)
                OP_PUSH: begin
                    ctl_d.ptr    = ptr_up;
                    ctl_d.we     = 1'b1;
                    ctl_d.waddr  = ptr_up;
                    ctl_d.occ_up = 1'b1;
                end
                OP_POP: begin
                    if (!empty) begin
                        ctl_d.ptr      = ptr_down;
                        ctl_d.occ_down = 1'b1;
                    end
                end
                OP_SWAP: begin
                    ctl_d.we = 1'b1;
                    if (empty) begin
                        ctl_d.ptr    = ptr_up;
                        ctl_d.waddr  = ptr_up;
                        ctl_d.occ_up = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) ptr_q <= '0;
        else     ptr_q <= ctl_d.ptr;
    end

    ras_occ #(.DEPTH(DEPTH)) u_occ (
        .clk   (clk),
        .rst   (rst),
        .up    (ctl_d.occ_up),
        .down  (ctl_d.occ_down),
        .count (occ_count),
        .empty (empty),
        .full  (full)
    );

    ras_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
        .clk   (clk),
        .we    (ctl_d.we),
        .waddr (ctl_d.waddr),
        .wdata (ctl_d.wdata),
        .raddr (ptr_q),
        .rdata (top_addr)
    );

    assign top_idx = ptr_q;

    assert_restore_lands_R7: assert property (@(posedge clk) disable iff (rst)
        restore_en |=> (top_idx == $past(restore_idx)) && (top_addr == $past(restore_addr)));

    assert_restore_keeps_flags_R8: assert property (@(posedge clk) disable iff (rst)
        restore_en |=> $stable(empty) && $stable(full));

    assert_push_shows_addr_R2: assert property (@(posedge clk) disable iff (rst)
        (push_en && !pop_en && !restore_en) |=> top_addr == $past(push_addr));

    assert_pop_empty_noop_R4: assert property (@(posedge clk) disable iff (rst)
        (pop_en && !push_en && !restore_en && empty) |=> $stable(top_idx) && empty);

    assert_swap_keeps_ptr_R9: assert property (@(posedge clk) disable iff (rst)
        (pop_en && push_en && !restore_en && !empty) |=>
            $stable(top_idx) && $stable(occ_count) && top_addr == $past(push_addr));
endmodule

// File: tb/ras_ring_top_bench.sv
`timescale 1ns/1ps
module ras_ring_top_bench;
    localparam int DEPTH = 8;
    localparam int AW = 32;
    localparam int PW = $clog2(DEPTH);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          push_en = 1'b0, pop_en = 1'b0, restore_en = 1'b0;
    logic [AW-1:0] push_addr = '0, restore_addr = '0;
    logic [PW-1:0] restore_idx = '0;
    logic [AW-1:0] top_addr;
    logic [PW-1:0] top_idx;
    logic          empty, full;

    int checks = 0;
    int errors = 0;

    int            m_ptr;
    int            m_cnt;
    logic [AW-1:0] m_mem   [DEPTH];
    bit            m_known [DEPTH];

    always #2.5 clk = ~clk;

    ras_ring_top #(.DEPTH(DEPTH), .AW(AW)) u_ras_ring_top (
        .clk(clk), .rst(rst), .push_en(push_en), .push_addr(push_addr),
        .pop_en(pop_en), .restore_en(restore_en), .restore_idx(restore_idx),
        .restore_addr(restore_addr), .top_addr(top_addr), .top_idx(top_idx),
        .empty(empty), .full(full)
    );

    task automatic check_int(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic compare_all(string tag);
        check_int(tag, "top_idx", int'(top_idx), m_ptr);
        check_int("R10", "empty", int'(empty), int'(m_cnt == 0));
        check_int("R10", "full", int'(full), int'(m_cnt == DEPTH));
        if (m_known[m_ptr]) begin
            checks++;
            if (top_addr !== m_mem[m_ptr]) begin
                errors++;
                $display("FAIL R6 (%s): top_addr actual=%h expected=%h", tag, top_addr, m_mem[m_ptr]);
            end
        end
    endtask

    // Behavioural model: one operation per clock, following the requirements.
    task automatic model_step(bit psh, bit pp, bit rs, int ridx, logic [AW-1:0] pa, logic [AW-1:0] ra);
        if (rs) begin
            m_ptr = ridx;
            m_mem[ridx] = ra;
            m_known[ridx] = 1;
        end else begin
            if (pp && m_cnt > 0) begin
                m_ptr = (m_ptr + DEPTH - 1) % DEPTH;
                m_cnt--;
            end
            if (psh) begin
                m_ptr = (m_ptr + 1) % DEPTH;
                m_mem[m_ptr] = pa;
                m_known[m_ptr] = 1;
                if (m_cnt < DEPTH) m_cnt++;
            end
        end
    endtask

    task automatic cycle(string tag, bit psh, bit pp, bit rs, int ridx,
                         logic [AW-1:0] pa, logic [AW-1:0] ra);
        push_en = psh; pop_en = pp; restore_en = rs;
        restore_idx = PW'(ridx); push_addr = pa; restore_addr = ra;
        @(posedge clk);
        model_step(psh, pp, rs, ridx, pa, ra);
        @(negedge clk);
        compare_all(tag);
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog: run did not complete");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        m_ptr = 0; m_cnt = 0;
        for (int i = 0; i < DEPTH; i++) m_known[i] = 0;
        repeat (3) @(negedge clk);
        compare_all("R1");                       // during reset
        rst = 1'b0;
        @(negedge clk);
        compare_all("R1");                       // first cycle after reset

        cycle("R4", 0, 1, 0, 0, '0, '0);         // pop on empty: no change
        cycle("R2", 1, 0, 0, 0, 32'h1000, '0);
        cycle("R2", 1, 0, 0, 0, 32'h1004, '0);
        cycle("R6", 1, 0, 0, 0, 32'h1008, '0);
        cycle("R3", 0, 1, 0, 0, '0, '0);
        cycle("R3", 0, 1, 0, 0, '0, '0);
        cycle("R3", 0, 1, 0, 0, '0, '0);
        cycle("R4", 0, 1, 0, 0, '0, '0);
        for (int i = 0; i < DEPTH; i++)          // fill: pointer wraps to 0 (R2)
            cycle("R2", 1, 0, 0, 0, 32'h2000 + i * 4, '0);
        cycle("R3", 0, 1, 0, 0, '0, '0);         // 0 -> DEPTH-1 wrap
        cycle("R5", 1, 0, 0, 0, 32'h3000, '0);   // back to full
        for (int i = 0; i < 3; i++)              // overwrite oldest while full
            cycle("R5", 1, 0, 0, 0, 32'h4000 + i * 4, '0);
        cycle("R9", 1, 1, 0, 0, 32'h5000, '0);   // replace top, nothing moves
        cycle("R7", 0, 0, 1, 5, '0, 32'h6000);
        cycle("R8", 1, 0, 1, 2, 32'h7777, 32'h6100);
        cycle("R8", 0, 1, 1, 6, '0, 32'h6200);
        cycle("R8", 1, 1, 1, 1, 32'h7778, 32'h6300);
        for (int i = 0; i < DEPTH + 2; i++)      // drain to empty
            cycle("R3", 0, 1, 0, 0, '0, '0);
        cycle("R9", 1, 1, 0, 0, 32'h8000, '0);   // swap on empty acts as push
        cycle("R7", 0, 0, 1, 4, '0, 32'h8100);   // restore keeps occupancy

        for (int i = 0; i < 400; i++) begin
            int r = $urandom_range(0, 99);
            bit ps = r < 45;
            bit pp = (r >= 35 && r < 80);
            bit rs = (r >= 92);
            cycle("R6", ps, pp, rs, $urandom_range(0, DEPTH - 1), $urandom, $urandom);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule